// File: doc/BRIEF.md
# Grouped Priority Preemption Arbiter

This block decides which pending exception a core should take next and whether that exception may interrupt the handler that is already running. Each exception source has a stored priority byte. Only the most significant bits of that byte are held in flops, and the remaining low bits always read as zero. A three-bit grouping setting divides every priority byte at a programmable point. The bits above the split form the group value and the bits below it form the sub value. A lower number means more urgent.

The arbiter chooses the winner among all pending sources by their full priority value. Because the group bits are the upper bits, this orders sources by group first and then by sub value. When two sources hold the same value, the lower index wins. Only the group part of the winner is compared against the group part of the active priority, and preemption needs a strictly smaller group value. The sub part therefore orders requests that are waiting but never causes preemption. Priorities and the grouping setting are loaded through a single-cycle write port. A read port returns any stored priority. The selection outputs are combinational from the stored settings and the live inputs.

Top module: `prio_group_arbiter`

## Requirements
- R1: After reset every stored priority reads 0x00 and the grouping setting reads 0.
- R2: A priority write (`wr_en`=1, `wr_cfg`=0) stores only the upper IMPL_BITS bits of `wr_data` into entry `wr_idx`. The low PRIO_W-IMPL_BITS bits are dropped and always read back as zero on `rd_prio`. The written value is visible from the next cycle.
- R3: A grouping write (`wr_en`=1, `wr_cfg`=1) stores `wr_data[2:0]` into `grp_cfg`, which is visible from the next cycle. A grouping write leaves every priority unchanged.
- R4: `sel_valid` is 1 exactly when any `pending` bit is set. `sel_idx` then names the pending source with the numerically lowest stored priority. When nothing is pending, `sel_idx` is 0.
- R5: Among pending sources with equal stored priority, the lowest index is selected.
- R6: With grouping value g, the group value of a priority is that priority with bits g..0 cleared. `preempt` is 1 exactly when `sel_valid` is 1 and either `act_valid` is 0 or the group value of the winner is strictly less than the group value of `active_prio`.
- R7: Grouping values 0, 1, 2 and 3 give identical selection and preemption results, because all four leave the four implemented bits entirely in the group part.
- R8: With grouping value 7 the group value is always zero, so `preempt` stays 0 whenever `act_valid` is 1.
- R9: With grouping value 5, bits 7:6 are group bits and bits 5:4 are sub bits. A winner that differs from the active priority only in bits 5:4 does not preempt.
- R10: `new_grp` equals the winner's group value when `preempt` is 1. Otherwise it equals the group value of `active_prio` when `act_valid` is 1, and 0xFF when `act_valid` is 0.
- R11: The low PRIO_W-IMPL_BITS bits of `active_prio` are treated as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_cfg | input | 1 | 1: write grouping setting, 0: write a priority entry |
| wr_idx | input | IDX_W | Entry written by a priority write |
| wr_data | input | PRIO_W | Write data |
| rd_idx | input | IDX_W | Entry shown on `rd_prio` |
| pending | input | N_SRC | Pending exception flags |
| act_valid | input | 1 | A handler is currently active |
| active_prio | input | PRIO_W | Priority of the active handler |
| grp_cfg | output | 3 | Current grouping setting |
| rd_prio | output | PRIO_W | Stored priority of entry `rd_idx` |
| sel_valid | output | 1 | Some source is pending |
| sel_idx | output | IDX_W | Selected source |
| preempt | output | 1 | Selected source preempts the active handler |
| new_grp | output | PRIO_W | Resulting active group priority |

## Verification
The bench builds the block with its defaults: eight sources, 8-bit priorities and four implemented bits. Four implemented bits give only sixteen levels across eight sources, so random loading produces frequent exact ties and frequent equal groups. This exercises the lowest-index rule and the strict-less-than preemption test heavily. The bench sweeps all eight grouping values under the same stimulus. This shows the aliasing of settings 0 to 3, the two-bit group split at setting 5, and the loss of all preemption at setting 7. The active priority is driven with nonzero low bits to show that those bits are ignored.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
   // Width of the grouping setting for an 8-bit priority byte
   localparam int GRP_CFG_W = 3;
   // Grouping value at which no group bits remain
   localparam logic [GRP_CFG_W-1:0] GRP_ALL_SUB = 3'd7;
endpackage

// File: rtl/prio_store.sv
module prio_store #(
   parameter int N_SRC     = 8,
   parameter int PRIO_W    = 8,
   parameter int IMPL_BITS = 4,
   parameter int GRP_W     = 3,
   parameter int IDX_W     = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      wr_cfg,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [PRIO_W-1:0]         wr_data,
   output logic [N_SRC*PRIO_W-1:0]   prio_flat,
   output logic [GRP_W-1:0]          grp_cfg
);
   localparam int LOW_W = PRIO_W - IMPL_BITS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                grp_cfg <= '0;
      else if (wr_en && wr_cfg)  grp_cfg <= wr_data[GRP_W-1:0];
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_ent
      logic [IMPL_BITS-1:0] hi_q;
      logic                 hit;
      assign hit = wr_en && !wr_cfg && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   hi_q <= '0;
         else if (hit) hi_q <= wr_data[PRIO_W-1 -: IMPL_BITS];
      end

      if (LOW_W > 0) begin : g_pad
         assign prio_flat[i*PRIO_W +: PRIO_W] = {hi_q, {LOW_W{1'b0}}};
      end else begin : g_full
         assign prio_flat[i*PRIO_W +: PRIO_W] = hi_q;
      end
   end
endmodule

// File: rtl/grp_split.sv
module grp_split #(
   parameter int PRIO_W = 8,
   parameter int GRP_W  = 3
) (
   input  logic [GRP_W-1:0]  grp_cfg,
   output logic [PRIO_W-1:0] grp_mask
);
   // Bit b belongs to the group part when it lies above the split point
   for (genvar b = 0; b < PRIO_W; b++) begin : g_bit
      assign grp_mask[b] = (int'(grp_cfg) < b);
   end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
   parameter int N_SRC  = 8,
   parameter int PRIO_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic [N_SRC-1:0]        pending,
   input  logic [N_SRC*PRIO_W-1:0] prio_flat,
   output logic                    win_any,
   output logic [IDX_W-1:0]        win_idx,
   output logic [PRIO_W-1:0]       win_prio
);
   // Strict comparison keeps the earlier (lower) index on ties
   always_comb begin
      win_any  = 1'b0;
      win_idx  = '0;
      win_prio = '1;
      for (int i = 0; i < N_SRC; i++) begin
         if (pending[i] && (!win_any || prio_flat[i*PRIO_W +: PRIO_W] < win_prio)) begin
            win_any  = 1'b1;
            win_prio = prio_flat[i*PRIO_W +: PRIO_W];
            win_idx  = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/prio_group_arbiter.sv
module prio_group_arbiter
   import prio_arb_pkg::*;
#(
   parameter int N_SRC     = 8,
   parameter int PRIO_W    = 8,
   parameter int IMPL_BITS = 4,
   parameter int IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 wr_cfg,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [PRIO_W-1:0]    wr_data,
   input  logic [IDX_W-1:0]     rd_idx,
   input  logic [N_SRC-1:0]     pending,
   input  logic                 act_valid,
   input  logic [PRIO_W-1:0]    active_prio,
   output logic [GRP_CFG_W-1:0] grp_cfg,
   output logic [PRIO_W-1:0]    rd_prio,
   output logic                 sel_valid,
   output logic [IDX_W-1:0]     sel_idx,
   output logic                 preempt,
   output logic [PRIO_W-1:0]    new_grp
);
   localparam int LOW_W = PRIO_W - IMPL_BITS;
   localparam logic [PRIO_W-1:0] IMPL_MASK = {PRIO_W{1'b1}} << LOW_W;

   initial begin
      assert (PRIO_W == (1 << GRP_CFG_W))
         else $error("PRIO_W must match the grouping setting width");
      assert (IMPL_BITS >= 1 && IMPL_BITS <= PRIO_W)
         else $error("IMPL_BITS out of range");
      assert (N_SRC >= 2 && N_SRC <= (1 << IDX_W))
         else $error("N_SRC does not fit IDX_W");
   end

   logic [N_SRC*PRIO_W-1:0] prio_flat;
   logic [PRIO_W-1:0]       grp_mask;
   logic                    win_any;
   logic [IDX_W-1:0]        win_idx;
   logic [PRIO_W-1:0]       win_prio;
   logic [PRIO_W-1:0]       win_grp;
   logic [PRIO_W-1:0]       act_grp;

   prio_store #(
      .N_SRC(N_SRC), .PRIO_W(PRIO_W), .IMPL_BITS(IMPL_BITS),
      .GRP_W(GRP_CFG_W), .IDX_W(IDX_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cfg(wr_cfg),
      .wr_idx(wr_idx), .wr_data(wr_data),
      .prio_flat(prio_flat), .grp_cfg(grp_cfg)
   );

   grp_split #(.PRIO_W(PRIO_W), .GRP_W(GRP_CFG_W)) u_split (
      .grp_cfg(grp_cfg), .grp_mask(grp_mask)
   );

   prio_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
      .pending(pending), .prio_flat(prio_flat),
      .win_any(win_any), .win_idx(win_idx), .win_prio(win_prio)
   );

   assign win_grp = win_prio & grp_mask;
   assign act_grp = active_prio & IMPL_MASK & grp_mask;

   assign sel_valid = win_any;
   assign sel_idx   = win_idx;
   assign preempt   = win_any && (!act_valid || (win_grp < act_grp));

   always_comb begin
      if (preempt)        new_grp = win_grp;
      else if (act_valid) new_grp = act_grp;
      else                new_grp = '1;
   end

   always_comb begin
      rd_prio = '0;
      for (int i = 0; i < N_SRC; i++)
         if (rd_idx == IDX_W'(i)) rd_prio = prio_flat[i*PRIO_W +: PRIO_W];
   end
endmodule

module prio_group_arbiter_chk #(
   parameter int N_SRC     = 8,
   parameter int PRIO_W    = 8,
   parameter int IMPL_BITS = 4,
   parameter int IDX_W     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_cfg,
   input logic [PRIO_W-1:0] wr_data,
   input logic [N_SRC-1:0]  pending,
   input logic              act_valid,
   input logic [2:0]        grp_cfg,
   input logic [PRIO_W-1:0] rd_prio,
   input logic              sel_valid,
   input logic [IDX_W-1:0]  sel_idx,
   input logic              preempt,
   input logic [PRIO_W-1:0] new_grp
);
   localparam logic [PRIO_W-1:0] LOW_MASK = ~({PRIO_W{1'b1}} << (PRIO_W - IMPL_BITS));

   assert_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_prio & LOW_MASK) == '0);

   assert_grp_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_cfg) |=> grp_cfg == $past(wr_data[2:0]));

   assert_any_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid == (pending != '0));

   assert_sel_is_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> pending[sel_idx]);

   assert_preempt_needs_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      preempt |-> sel_valid);

   assert_no_preempt_all_sub_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_cfg == 3'd7 && act_valid) |-> !preempt);

   assert_idle_group_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_valid && !preempt) |-> new_grp == '1);
endmodule

bind prio_group_arbiter prio_group_arbiter_chk #(
   .N_SRC(N_SRC), .PRIO_W(PRIO_W), .IMPL_BITS(IMPL_BITS), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cfg(wr_cfg), .wr_data(wr_data),
   .pending(pending), .act_valid(act_valid), .grp_cfg(grp_cfg), .rd_prio(rd_prio),
   .sel_valid(sel_valid), .sel_idx(sel_idx), .preempt(preempt), .new_grp(new_grp)
);

// File: tb/prio_group_arbiter_test.sv
module prio_group_arbiter_test;
   localparam int N  = 8;
   localparam int PW = 8;
   localparam int IB = 4;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, wr_cfg = 1'b0;
   logic [IW-1:0] wr_idx = '0, rd_idx = '0;
   logic [PW-1:0] wr_data = '0, active_prio = '0;
   logic [N-1:0]  pending = '0;
   logic          act_valid = 1'b0;
   logic [2:0]    grp_cfg;
   logic [PW-1:0] rd_prio, new_grp;
   logic          sel_valid, preempt;
   logic [IW-1:0] sel_idx;

   always #2 clk = ~clk;  // 250 MHz

   prio_group_arbiter #(.N_SRC(N), .PRIO_W(PW), .IMPL_BITS(IB), .IDX_W(IW)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cfg(wr_cfg), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .pending(pending), .act_valid(act_valid),
      .active_prio(active_prio), .grp_cfg(grp_cfg), .rd_prio(rd_prio),
      .sel_valid(sel_valid), .sel_idx(sel_idx), .preempt(preempt), .new_grp(new_grp)
   );

   // reference model state
   int    m_prio[N];
   int    m_grp;
   int    n_vec = 0, n_bad = 0;
   bit    done = 0;
   string phase = "R1 reset";

   function automatic int gmask(int g);
      return (255 << (g + 1)) & 255;
   endfunction

   task automatic fail_line(string fld, int act, int exp);
      n_bad++;
      $display("FAIL %s field %s: actual 0x%0h expected 0x%0h", phase, fld, act, exp);
   endtask

   // compare all outputs against the model for the current inputs
   task automatic compare();
      int best_i, best_p, m, wg, ag, e_pre, e_new;
      bit any;
      any = 0; best_i = 0; best_p = 255;
      for (int i = 0; i < N; i++)
         if (pending[i] && (!any || m_prio[i] < best_p)) begin
            any = 1; best_p = m_prio[i]; best_i = i;
         end
      m  = gmask(m_grp);
      wg = best_p & m;
      ag = int'(active_prio) & 8'hF0 & m;
      e_pre = (any && (!act_valid || wg < ag)) ? 1 : 0;
      e_new = e_pre ? wg : (act_valid ? ag : 255);
      n_vec++;
      if (int'(sel_valid) != int'(any))   fail_line("sel_valid R4", sel_valid, any);
      if (int'(sel_idx) != best_i)        fail_line("sel_idx R4/R5", sel_idx, best_i);
      if (int'(preempt) != e_pre)         fail_line("preempt R6", preempt, e_pre);
      if (int'(new_grp) != e_new)         fail_line("new_grp R10", new_grp, e_new);
      if (int'(rd_prio) != m_prio[rd_idx]) fail_line("rd_prio R2", rd_prio, m_prio[rd_idx]);
      if (int'(grp_cfg) != m_grp)         fail_line("grp_cfg R3", grp_cfg, m_grp);
   endtask

   // one cycle: inputs already set at negedge, compare, then commit at posedge
   task automatic cycle();
      #1 compare();
      @(posedge clk);
      if (wr_en) begin
         if (wr_cfg) m_grp = int'(wr_data[2:0]);
         else        m_prio[wr_idx] = int'(wr_data) & 8'hF0;
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rand_traffic(int cycles, bit act_lowbits);
      for (int k = 0; k < cycles; k++) begin
         pending     = N'($urandom);
         if ($urandom_range(0, 7) == 0) pending = '0;
         act_valid   = ($urandom_range(0, 3) != 0);
         active_prio = PW'($urandom);
         if (!act_lowbits) active_prio[3:0] = 4'h0;
         rd_idx      = IW'($urandom);
         if ($urandom_range(0, 5) == 0) begin
            wr_en = 1'b1; wr_cfg = 1'b0;
            wr_idx = IW'($urandom); wr_data = PW'($urandom);
         end
         cycle();
      end
   endtask

   task automatic set_grp(int g);
      wr_en = 1'b1; wr_cfg = 1'b1; wr_data = PW'($urandom); wr_data[2:0] = 3'(g);
      cycle();
   endtask

   initial begin
      for (int i = 0; i < N; i++) m_prio[i] = 0;
      m_grp = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: state after reset, scanning every entry
      phase = "R1 reset";
      for (int i = 0; i < N; i++) begin rd_idx = IW'(i); cycle(); end

      // R2: load priorities with nonzero low bits, then read each back
      phase = "R2 write low bits ignored";
      for (int i = 0; i < N; i++) begin
         wr_en = 1'b1; wr_cfg = 1'b0; wr_idx = IW'(i);
         wr_data = PW'((i * 37 + 5) | 1); rd_idx = IW'(i);
         cycle();
      end
      for (int i = 0; i < N; i++) begin rd_idx = IW'(i); cycle(); end

      // R5: force ties at the same level, selection must pick lowest index
      phase = "R5 ties";
      for (int i = 0; i < N; i++) begin
         wr_en = 1'b1; wr_cfg = 1'b0; wr_idx = IW'(i); wr_data = 8'h6C;
         cycle();
      end
      for (int k = 0; k < 40; k++) begin
         pending = N'($urandom); act_valid = 1'b0; cycle();
      end

      // R7: sweep groupings 0..3 under random traffic
      for (int g = 0; g < 4; g++) begin
         phase = $sformatf("R7 grouping %0d", g);
         set_grp(g);
         rand_traffic(300, 0);
      end

      // R9: grouping 5 with a sub-only difference
      phase = "R9 grouping 5";
      set_grp(5);
      wr_en = 1'b1; wr_cfg = 1'b0; wr_idx = 3'd2; wr_data = 8'h40; cycle();
      pending = 8'b0000_0100; act_valid = 1'b1; active_prio = 8'h70; cycle(); // same group, no preempt
      active_prio = 8'h80; cycle();                                          // lower group, preempt
      rand_traffic(300, 0);

      // R8: grouping 7, nothing preempts an active handler
      phase = "R8 grouping 7";
      set_grp(7);
      rand_traffic(300, 0);

      // R3: grouping writes 4 and 6 with stray upper data bits
      phase = "R3 grouping write";
      set_grp(4); rand_traffic(100, 0);
      set_grp(6); rand_traffic(100, 0);

      // R11: active priority low bits set
      phase = "R11 active low bits";
      set_grp(0); rand_traffic(200, 1);
      set_grp(5); rand_traffic(200, 1);

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog expired: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule